// File: doc/BRIEF.md
# Masked Vector Scatter-Prefetch Address Sequencer

This block accepts one vector prefetch-for-write operation and unrolls it into a stream of single-byte-address prefetch requests. The operation is described by a packed index vector, a per-lane enable mask, an optional base address, a scale, a displacement and a two-bit variant code. The variant code selects the index width and the lane count. On a start pulse the block captures all operands. It then walks the enabled lanes from the lowest to the highest. For each lane it forms the effective address and offers it as a request on a valid/ready handshake.

Every request asks for the line to be placed in the first-level cache with ownership, ready for a later write. The block never faults and never checks alignment. Each address is a single byte address, so nothing is split at a line boundary. The captured mask is echoed back unchanged. A busy flag covers the whole operation, and a one-cycle done pulse marks its end. A start that arrives while busy is dropped.

Top module: `scatter_pf_seq`

## Requirements
- R1: Each request address equals base + (sign-extended index << scale_i) + sign-extended 32-bit displacement, computed modulo 2^64. scale_i codes 0, 1, 2 and 3 mean factors 1, 2, 4 and 8.
- R2: The variant code selects how lanes are read from the index vector:
  - 0: 16 lanes of 32-bit indices, lane j at bits [32j+31:32j].
  - 1: 8 lanes of 32-bit indices from the low 256 bits.
  - 2 and 3: 8 lanes of 64-bit indices, lane j at bits [64j+63:64j].
  - For the 8-lane variants, mask bits 15..8 and index bits outside the selected lanes have no effect.
- R3: A request is issued only for an enabled lane whose mask bit is 1. Lanes are issued in ascending order, at most one per cycle. Disabled lanes cost no cycle. The first request is valid in the cycle after start, and accepted lanes follow back to back while ready stays high.
- R4: While req_valid_o is high and req_ready_i is low, the request stays valid and its address stays unchanged.
- R5: Every request shows req_own_o = 1 and req_level_o = 2'd0, where code 0 means the first-level cache.
- R6: When base_vld_i is 0 at start, the base term is zero, whatever the value on base_i.
- R7: busy_o is high from the cycle after an accepted start until the last request is accepted. done_o is high for exactly the one cycle after that last handshake, with busy_o and req_valid_o low.
- R8: If no enabled lane has its mask bit set, done_o is high in the cycle after start, busy_o stays low and no request is issued.
- R9: A start pulse while busy_o is high is ignored. The ongoing request stream and mask_o are unaffected.
- R10: From the cycle after an accepted start, mask_o shows the full 16-bit mask_i captured at that start. It is never altered as lanes complete, and it holds until the next accepted start.
- R11: After reset, req_valid_o, busy_o and done_o are 0 and mask_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse; operands are captured when not busy |
| variant_i | input | 2 | Index width / lane count code (R2) |
| base_i | input | 64 | Base address |
| base_vld_i | input | 1 | Base present; 0 means the base term is zero |
| index_i | input | 512 | Packed index vector |
| mask_i | input | 16 | Per-lane enable mask |
| scale_i | input | 2 | log2 of the index scale factor |
| disp_i | input | 32 | Signed displacement (already sign-extended from 1, 2 or 4 bytes) |
| req_ready_i | input | 1 | Downstream accepts the request |
| req_valid_o | output | 1 | Request valid |
| req_addr_o | output | 64 | Request byte address |
| req_level_o | output | 2 | Target cache level code, 0 = first level |
| req_own_o | output | 1 | Ownership (intent to write) flag |
| mask_o | output | 16 | Captured mask, returned unchanged |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle end-of-operation pulse |

## Verification
The assertions watch four things on every cycle:
- the request is held steady under back-pressure;
- the lane order is strictly ascending and only pending lanes are offered;
- mask_o is stable unless a start is accepted;
- done_o coincides with idle, including the empty-mask case.

The address arithmetic needs the directed scenarios, because it depends on values rather than on cycle relations. These scenarios cover each variant's lane extraction, negative indices, the absent base and 64-bit wraparound. The scenarios also compare the request stream with a model to show that mask bits above an 8-lane variant are ignored and that a start arriving mid-operation leaves the stream untouched.

// File: rtl/scatter_pf_pkg.sv
package scatter_pf_pkg;

    typedef enum logic [1:0] {
        VAR_W32_L16 = 2'd0,
        VAR_W32_L8  = 2'd1,
        VAR_W64_SP  = 2'd2,
        VAR_W64_DP  = 2'd3
    } variant_e;

    localparam logic [1:0] LEVEL_FIRST = 2'd0;

endpackage

// File: rtl/spf_lane_pick.sv
module spf_lane_pick #(
    parameter int LANES  = 16,
    parameter int LANE_W = $clog2(LANES)
) (
    input  logic [LANES-1:0]  pend_i,
    output logic [LANE_W-1:0] lane_o,
    output logic              any_o
);

    // Lowest set bit wins: scan downward so the last hit is the lowest.
    always_comb begin
        lane_o = '0;
        for (int i = LANES - 1; i >= 0; i--) begin
            if (pend_i[i]) lane_o = LANE_W'(i);
        end
        any_o = |pend_i;
    end

endmodule

// File: rtl/spf_addr_calc.sv
module spf_addr_calc #(
    parameter int ADDR_W = 64,
    parameter int LANES  = 16,
    parameter int DISP_W = 32,
    parameter int IDX_W  = LANES * 32,
    parameter int LANE_W = $clog2(LANES)
) (
    input  logic [IDX_W-1:0]  idx_vec_i,
    input  logic [LANE_W-1:0] lane_i,
    input  logic              wide_i,
    input  logic [ADDR_W-1:0] base_i,
    input  logic              base_vld_i,
    input  logic [1:0]        scale_i,
    input  logic [DISP_W-1:0] disp_i,
    output logic [ADDR_W-1:0] addr_o
);

    localparam int HALF = LANES / 2;

    logic [ADDR_W-1:0] idx32 [LANES];
    logic [ADDR_W-1:0] idx64 [HALF];
    logic [ADDR_W-1:0] sel_idx;
    logic [ADDR_W-1:0] base_term;

    for (genvar j = 0; j < LANES; j++) begin : g_narrow
        assign idx32[j] = ADDR_W'($signed(idx_vec_i[j*32 +: 32]));
    end

    for (genvar j = 0; j < HALF; j++) begin : g_wide
        assign idx64[j] = ADDR_W'($signed(idx_vec_i[j*64 +: 64]));
    end

    always_comb begin
        sel_idx   = wide_i ? idx64[lane_i[LANE_W-2:0]] : idx32[lane_i];
        base_term = base_vld_i ? base_i : '0;
        addr_o    = base_term + (sel_idx << scale_i) + ADDR_W'($signed(disp_i));
    end

endmodule

// File: rtl/scatter_pf_seq.sv
module scatter_pf_seq
    import scatter_pf_pkg::*;
#(
    parameter int ADDR_W = 64,
    parameter int LANES  = 16,
    parameter int DISP_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [1:0]        variant_i,
    input  logic [ADDR_W-1:0] base_i,
    input  logic              base_vld_i,
    input  logic [LANES*32-1:0] index_i,
    input  logic [LANES-1:0]  mask_i,
    input  logic [1:0]        scale_i,
    input  logic [DISP_W-1:0] disp_i,
    input  logic              req_ready_i,
    output logic              req_valid_o,
    output logic [ADDR_W-1:0] req_addr_o,
    output logic [1:0]        req_level_o,
    output logic              req_own_o,
    output logic [LANES-1:0]  mask_o,
    output logic              busy_o,
    output logic              done_o
);

    localparam int IDX_W  = LANES * 32;
    localparam int LANE_W = $clog2(LANES);
    localparam int HALF   = LANES / 2;

    typedef struct packed {
        logic              busy;
        logic              done;
        logic              wide;
        logic [LANES-1:0]  pend;
        logic [LANES-1:0]  mask;
        logic [ADDR_W-1:0] base;
        logic              base_vld;
        logic [1:0]        scale;
        logic [DISP_W-1:0] disp;
        logic [IDX_W-1:0]  idx;
    } seq_state_t;

    seq_state_t st_d, st_q;

    logic [LANES-1:0]  lane_en;
    logic [LANES-1:0]  act_mask;
    logic [LANE_W-1:0] pick_lane;
    logic              pick_any;
    logic [LANES-1:0]  pend_after;
    logic              handshake;

    always_comb begin
        if (variant_i == VAR_W32_L16) lane_en = '1;
        else                          lane_en = {{(LANES-HALF){1'b0}}, {HALF{1'b1}}};
        act_mask = mask_i & lane_en;
    end

    spf_lane_pick #(.LANES(LANES)) u_pick (
        .pend_i (st_q.pend),
        .lane_o (pick_lane),
        .any_o  (pick_any)
    );

    spf_addr_calc #(
        .ADDR_W (ADDR_W),
        .LANES  (LANES),
        .DISP_W (DISP_W)
    ) u_addr (
        .idx_vec_i  (st_q.idx),
        .lane_i     (pick_lane),
        .wide_i     (st_q.wide),
        .base_i     (st_q.base),
        .base_vld_i (st_q.base_vld),
        .scale_i    (st_q.scale),
        .disp_i     (st_q.disp),
        .addr_o     (req_addr_o)
    );

    assign handshake = st_q.busy && pick_any && req_ready_i;

    always_comb begin
        st_d       = st_q;
        st_d.done  = 1'b0;
        pend_after = st_q.pend & ~(LANES'(1) << pick_lane);
        if (!st_q.busy && start_i) begin
            st_d.wide     = variant_i[1];
            st_d.pend     = act_mask;
            st_d.mask     = mask_i;
            st_d.base     = base_i;
            st_d.base_vld = base_vld_i;
            st_d.scale    = scale_i;
            st_d.disp     = disp_i;
            st_d.idx      = index_i;
            st_d.busy     = |act_mask;
            st_d.done     = ~|act_mask;
        end else if (handshake) begin
            st_d.pend = pend_after;
            if (pend_after == '0) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign req_valid_o = st_q.busy && pick_any;
    assign req_level_o = LEVEL_FIRST;
    assign req_own_o   = 1'b1;
    assign mask_o      = st_q.mask;
    assign busy_o      = st_q.busy;
    assign done_o      = st_q.done;

    assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid_o && !req_ready_i |=> req_valid_o && $stable(req_addr_o));

    assert_ascending_R3: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid_o && req_ready_i && ($countones(st_q.pend) > 1)
        |=> req_valid_o && (pick_lane > $past(pick_lane)));

    assert_lane_pending_R3: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid_o |-> st_q.pend[pick_lane]);

    assert_mask_kept_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(start_i && !busy_o) |=> $stable(mask_o));

    assert_busy_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o && start_i |=> $stable(mask_o));

    assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o && !req_valid_o);

    assert_empty_op_R8: assert property (@(posedge clk) disable iff (!rst_n)
        start_i && !busy_o && (act_mask == '0) |=> done_o && !busy_o && !req_valid_o);

endmodule

// File: tb/scatter_pf_seq_tb_top.sv
`timescale 1ns/1ps
module scatter_pf_seq_tb_top;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         start_i;
    logic [1:0]   variant_i;
    logic [63:0]  base_i;
    logic         base_vld_i;
    logic [511:0] index_i;
    logic [15:0]  mask_i;
    logic [1:0]   scale_i;
    logic [31:0]  disp_i;
    logic         req_ready_i;
    logic         req_valid_o;
    logic [63:0]  req_addr_o;
    logic [1:0]   req_level_o;
    logic         req_own_o;
    logic [15:0]  mask_o;
    logic         busy_o;
    logic         done_o;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    scatter_pf_seq dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .variant_i   (variant_i),
        .base_i      (base_i),
        .base_vld_i  (base_vld_i),
        .index_i     (index_i),
        .mask_i      (mask_i),
        .scale_i     (scale_i),
        .disp_i      (disp_i),
        .req_ready_i (req_ready_i),
        .req_valid_o (req_valid_o),
        .req_addr_o  (req_addr_o),
        .req_level_o (req_level_o),
        .req_own_o   (req_own_o),
        .mask_o      (mask_o),
        .busy_o      (busy_o),
        .done_o      (done_o)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [511:0] mk_idx(input logic [31:0] seed);
        logic [511:0] r;
        logic [31:0]  x;
        x = seed ^ 32'h9E37_79B9;
        for (int j = 0; j < 16; j++) begin
            x = x ^ (x << 13);
            x = x ^ (x >> 17);
            x = x ^ (x << 5);
            r[j*32 +: 32] = x;
        end
        return r;
    endfunction

    function automatic logic [63:0] ref_addr(input logic [1:0] v, input logic [511:0] iv,
                                             input int lane, input logic [63:0] b,
                                             input logic bv, input logic [1:0] sc,
                                             input logic [31:0] d);
        logic [63:0] ix;
        if (v >= 2'd2) ix = iv[lane*64 +: 64];
        else           ix = {{32{iv[lane*32+31]}}, iv[lane*32 +: 32]};
        return (bv ? b : 64'd0) + (ix << sc) + {{32{d[31]}}, d};
    endfunction

    // ready_mode: 0 always ready, 1 alternate, 2 ready one cycle in three
    task automatic run_op(input logic [1:0] v, input logic [511:0] iv, input logic [15:0] m,
                          input logic [63:0] b, input logic bv, input logic [1:0] sc,
                          input logic [31:0] d, input int ready_mode, input bit restart,
                          input string tag);
        logic [63:0] q[$];
        int          nl;
        int          k;
        bit          seen_done;
        bit          prev_stall;
        logic [63:0] prev_addr;
        nl = (v == 2'd0) ? 16 : 8;
        for (int l = 0; l < nl; l++)
            if (m[l]) q.push_back(ref_addr(v, iv, l, b, bv, sc, d));
        @(negedge clk);
        variant_i = v; index_i = iv; mask_i = m; base_i = b; base_vld_i = bv;
        scale_i = sc; disp_i = d; start_i = 1'b1; req_ready_i = 1'b0;
        @(negedge clk);
        start_i = 1'b0;
        chk(mask_o == m, "R10", {tag, " mask echo"}, 64'(mask_o), 64'(m));
        chk(busy_o == (q.size() != 0), "R7", {tag, " busy after start"}, 64'(busy_o), 64'(q.size() != 0));
        k = 0; seen_done = 0; prev_stall = 0; prev_addr = '0;
        for (int cyc = 0; cyc < 200; cyc++) begin
            case (ready_mode)
                0:       req_ready_i = 1'b1;
                1:       req_ready_i = cyc[0];
                default: req_ready_i = (cyc % 3 == 2);
            endcase
            if (restart && cyc == 1) begin
                start_i = 1'b1; mask_i = 16'hFFFF; index_i = ~iv; base_i = ~b; variant_i = 2'd0;
            end else begin
                start_i = 1'b0;
            end
            #1;
            if (prev_stall)
                chk(req_valid_o && req_addr_o == prev_addr, "R4", {tag, " held under stall"}, req_addr_o, prev_addr);
            if (done_o) begin
                seen_done = 1;
                break;
            end
            if (req_valid_o) begin
                if (k < q.size())
                    chk(req_addr_o == q[k], "R1", {tag, " lane address/order (R3)"}, req_addr_o, q[k]);
                else
                    chk(1'b0, "R3", {tag, " extra request"}, req_addr_o, 64'd0);
                chk(req_own_o == 1'b1 && req_level_o == 2'd0, "R5", {tag, " own/level"},
                    {61'd0, req_level_o, req_own_o}, 64'd1);
                if (req_ready_i) k++;
                prev_stall = !req_ready_i;
                prev_addr  = req_addr_o;
            end else begin
                prev_stall = 0;
            end
            @(negedge clk);
        end
        start_i = 1'b0;
        chk(seen_done, "R7", {tag, " done seen"}, 64'(seen_done), 64'd1);
        chk(k == q.size(), "R3", {tag, " request count"}, 64'(k), 64'(q.size()));
        chk(!busy_o, "R7", {tag, " idle at done"}, 64'(busy_o), 64'd0);
        chk(mask_o == m, "R10", {tag, " mask unchanged at end"}, 64'(mask_o), 64'(m));
        @(negedge clk);
        #1;
        chk(!done_o && !req_valid_o, "R7", {tag, " done one cycle"}, {62'd0, done_o, req_valid_o}, 64'd0);
    endtask

    task automatic t_reset;
        rst_n = 1'b0; start_i = 0; variant_i = 0; base_i = 0; base_vld_i = 0; index_i = '0;
        mask_i = 0; scale_i = 0; disp_i = 0; req_ready_i = 0;
        repeat (3) @(negedge clk);
        chk(!req_valid_o && !busy_o && !done_o && mask_o == 16'd0, "R11", "reset state",
            {45'd0, req_valid_o, busy_o, done_o, mask_o}, 64'd0);
        rst_n = 1'b1;
    endtask

    task automatic t_wide_dp;   // R1 R3: 64-bit indices, sparse mask, always ready
        run_op(2'd3, mk_idx(32'd1), 16'h00B5, 64'h0000_4000_0000_0000, 1'b1, 2'd3, 32'hFFFF_FF80, 0, 0, "wide_dp");
    endtask

    task automatic t_narrow16;  // R2 R4: 16 lanes, negative indices, alternating ready
        run_op(2'd0, mk_idx(32'd2), 16'hA5C3, 64'h0000_0000_1000_0000, 1'b1, 2'd2, 32'h0000_0010, 1, 0, "narrow16");
    endtask

    task automatic t_narrow8;   // R2: upper mask bits and upper index half ignored
        run_op(2'd1, mk_idx(32'd3), 16'hFF5A, 64'h0000_0000_2000_0000, 1'b1, 2'd1, 32'h0000_0004, 2, 0, "narrow8");
    endtask

    task automatic t_nobase_wrap; // R6 R1: base absent, then 64-bit wrap
        run_op(2'd2, mk_idx(32'd4), 16'h00FF, 64'hDEAD_BEEF_0000_0000, 1'b0, 2'd0, 32'h0000_0100, 0, 0, "nobase");
        run_op(2'd3, {8{64'h0000_0000_0000_0020}}, 16'h0081, 64'hFFFF_FFFF_FFFF_FFF0, 1'b1, 2'd3, 32'h0000_0008, 1, 0, "wrap");
    endtask

    task automatic t_empty;     // R8: no active lane, including only-upper bits for 8 lanes
        run_op(2'd0, mk_idx(32'd5), 16'h0000, 64'h1000, 1'b1, 2'd0, 32'd0, 0, 0, "empty16");
        run_op(2'd2, mk_idx(32'd6), 16'hFF00, 64'h1000, 1'b1, 2'd0, 32'd0, 0, 0, "empty8_R2");
    endtask

    task automatic t_restart;   // R9: start while busy has no effect
        run_op(2'd3, mk_idx(32'd7), 16'h00E7, 64'h0000_0000_8000_0000, 1'b1, 2'd1, 32'hFFFF_0000, 2, 1, "restart_R9");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_wide_dp();
        t_narrow16();
        t_narrow8();
        t_nobase_wrap();
        t_empty();
        t_restart();
        repeat (4) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule